// File: doc/BRIEF.md
# Converter Serial Register Port

This block is the device side of the serial port on a two-channel converter. The host reaches it as an SPI slave in mode 3: clock idle high, the device changes its output after a falling edge and samples on the rising edge, most significant bit first, framed by an active-low chip select. The serial pins are oversampled in the system clock domain. Every access starts with an 8-bit command byte. The command picks a register, the direction and the channel, and sets the standby flag. The register it picks fixes how long the next transfer is.

The register file holds setup, clock, test, data, offset and gain registers. A simple stream input stands in for the converter's results. A word is accepted on a cycle where `conv_valid` and `conv_ready` are both high. The upstream side must hold the word and `conv_valid` steady until that cycle. `conv_ready` drops while a read of the data register is open, while standby is set, while a calibration is running, and in the cycle a run-of-ones reset lands. This means a result can never change under a read that is in progress. Writing a calibration mode into the setup register starts a fixed-length stub calibration, and the mode bits clear themselves when it ends. A run of 32 ones on the data input puts the port and all registers back to their reset state.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, setup reads 0x01, clock reads 0x05, offset reads 0x800000, `drdy_n` is 1, `sdo_oe` is 0, `standby` is 0, `channel` is 0 and `conv_ready` is 1.
- R2: The command byte is laid out as follows: bit 7 must be 0, bits 6:4 are the register select, bit 3 is 1 for read, bit 2 is standby and bits 1:0 are the channel. A command byte with bit 7 set is ignored in full, and the next byte is again taken as a command.
- R3: Selects 0 (command), 1 (setup), 2 (clock) and 4 (test) move 8 bits, select 3 (data) moves 16 bits, and selects 6 (offset) and 7 (gain) move 24 bits. Select 5, and a write to select 0, open no data transfer. After each data transfer the next byte is a command.
- R4: Read data leaves on `sdo` MSB first. It changes after a falling SCK edge and is valid at the rising edge. `sdo_oe` is high only while chip select is low and a read transfer is open.
- R5: Clock register bits 7:5 read back as zero whatever was written.
- R6: A 16-bit write to the data register is clocked in but leaves the stored result unchanged.
- R7: A setup write with bits 7:6 non-zero holds the mode while the calibration runs for CAL_CYCLES clocks. After that, bits 7:6 read 00 and `drdy_n` goes low.
- R8: An accepted conversion word replaces the data register and drives `drdy_n` low. `conv_ready` is low during an open data-register read and during standby.
- R9: A completed 16-bit read of the data register drives `drdy_n` high.
- R10: 32 consecutive rising SCK edges with `din` high, with chip select low, restore every register to its reset value and the port to command phase. 31 ones followed by a chip-select release do not.
- R11: Releasing chip select discards a partly received byte and restarts the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle high |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| conv_valid | input | 1 | Conversion word offered |
| conv_ready | output | 1 | Conversion word can be taken this cycle |
| conv_data | input | 16 | Conversion word |
| drdy_n | output | 1 | Data-ready flag, active low |
| standby | output | 1 | Standby bit of the last command |
| channel | output | 2 | Channel field of the last command |

## Verification
Two functions can meet in one cycle: accepting a new conversion word, and ending a read of the data register, which raises `drdy_n`. The bench offers a new word with `conv_valid` held high from the moment the read command lands until after the read ends. It then judges three things. The read must return the old word intact. `conv_ready` must stay low while the read is open. After the release, `drdy_n` must be low again and a second read must return the new word. This shows that the completion took effect and the held word was accepted afterwards, not lost and not torn.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

  typedef enum logic [2:0] {
    SEL_COMM   = 3'd0,
    SEL_SETUP  = 3'd1,
    SEL_CLOCK  = 3'd2,
    SEL_DATA   = 3'd3,
    SEL_TEST   = 3'd4,
    SEL_NOP    = 3'd5,
    SEL_OFFSET = 3'd6,
    SEL_GAIN   = 3'd7
  } sel_e;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  localparam int unsigned WORD_W = 24;
  localparam int unsigned CONV_W = 16;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  localparam logic [7:0]        SETUP_RST  = 8'h01;
  localparam logic [7:0]        CLOCK_RST  = 8'h05;
  localparam logic [WORD_W-1:0] OFFSET_RST = 24'h800000;
  localparam logic [WORD_W-1:0] GAIN_RST   = 24'h500000;

  typedef struct packed {
    logic              drdy_n;
    logic [6:0]        comm;
    logic [7:0]        setup;
    logic [7:0]        clock;
    logic [7:0]        test;
    logic [CONV_W-1:0] data;
    logic [WORD_W-1:0] offset;
    logic [WORD_W-1:0] gain;
  } regfile_t;

  localparam regfile_t RF_RST = '{
    drdy_n: 1'b1, comm: 7'h00, setup: SETUP_RST, clock: CLOCK_RST,
    test: 8'h00, data: '0, offset: OFFSET_RST, gain: GAIN_RST
  };

  function automatic logic [CNT_W-1:0] sel_bits(sel_e s);
    case (s)
      SEL_DATA:             sel_bits = CNT_W'(16);
      SEL_OFFSET, SEL_GAIN: sel_bits = CNT_W'(24);
      default:              sel_bits = CNT_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic din_s
);
  logic [STAGES-1:0] sk_p, cs_p, di_p;
  logic              sk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_p    <= '1;
      cs_p    <= '1;
      di_p    <= '0;
      sk_last <= 1'b1;
    end else begin
      sk_p    <= {sk_p[STAGES-2:0], sclk};
      cs_p    <= {cs_p[STAGES-2:0], cs_n};
      di_p    <= {di_p[STAGES-2:0], din};
      sk_last <= sk_p[STAGES-1];
    end
  end

  assign sclk_rise = sk_p[STAGES-1] & ~sk_last;
  assign sclk_fall = ~sk_p[STAGES-1] & sk_last;
  assign cs_act    = ~cs_p[STAGES-1];
  assign din_s     = di_p[STAGES-1];
endmodule

// File: rtl/adc_sif_shift.sv
module adc_sif_shift
  import adc_sif_pkg::*;
#(
  parameter int unsigned ONES_RUN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              cs_act,
  input  logic              din,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic              load_tx,
  input  logic [WORD_W-1:0] tx_word,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sdo_bit,
  output logic              ones_hit
);
  localparam int unsigned RUN_W = $clog2(ONES_RUN + 1);

  logic [CNT_W-1:0]  cnt;
  logic [RUN_W-1:0]  run;
  logic [WORD_W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      run       <= '0;
      tx        <= '0;
      rx_word   <= '0;
      word_done <= 1'b0;
      ones_hit  <= 1'b0;
    end else begin
      word_done <= 1'b0;
      ones_hit  <= 1'b0;
      if (!cs_act) begin
        cnt <= '0;
        run <= '0;
      end else if (rise) begin
        rx_word <= {rx_word[WORD_W-2:0], din};
        if (din && run == RUN_W'(ONES_RUN - 1)) begin
          run      <= '0;
          cnt      <= '0;
          ones_hit <= 1'b1;
        end else begin
          run <= din ? run + 1'b1 : '0;
          if (cnt == xfer_len - 1'b1) begin
            cnt       <= '0;
            word_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      if (load_tx)
        tx <= tx_word;
      else if (cs_act && fall && cnt != '0)
        tx <= {tx[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo_bit = tx[WORD_W-1];
endmodule

// File: rtl/adc_sif_regs.sv
module adc_sif_regs
  import adc_sif_pkg::*;
#(
  parameter int unsigned CAL_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              word_done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              ones_hit,
  input  logic              conv_valid,
  input  logic [CONV_W-1:0] conv_data,
  output logic [CNT_W-1:0]  xfer_len,
  output logic              load_tx,
  output logic [WORD_W-1:0] tx_word,
  output logic              rd_active,
  output logic              conv_ready,
  output logic              drdy_n,
  output logic              standby,
  output logic [1:0]        channel,
  output logic              cal_done,
  output logic              rd_data_done,
  output logic              setup_wr,
  output logic [7:0]        setup_q,
  output logic [7:0]        clock_q
);
  localparam int unsigned CAL_W = $clog2(CAL_CYCLES + 1);
  localparam int unsigned PAD8  = WORD_W - 8;
  localparam int unsigned PAD16 = WORD_W - CONV_W;

  regfile_t   rf;
  phase_e     phase;
  sel_e       cur_sel;
  logic       cur_rd;
  logic [CAL_W-1:0] cal_cnt;

  logic [7:0] cmd_byte;
  sel_e       cmd_sel;
  logic       cmd_rd, cmd_take, cmd_open, data_end, wr_end;

  assign cmd_byte = rx_word[7:0];
  assign cmd_sel  = sel_e'(cmd_byte[6:4]);
  assign cmd_rd   = cmd_byte[3];
  assign cmd_take = word_done && cs_act && !ones_hit && phase == PH_CMD && !cmd_byte[7];
  assign cmd_open = cmd_take && cmd_sel != SEL_NOP && (cmd_rd || cmd_sel != SEL_COMM);
  assign data_end = word_done && cs_act && !ones_hit && phase == PH_DATA;
  assign wr_end   = data_end && !cur_rd;

  assign setup_wr     = wr_end && cur_sel == SEL_SETUP;
  assign rd_data_done = data_end && cur_rd && cur_sel == SEL_DATA;
  assign cal_done     = cal_cnt == CAL_W'(1);
  assign rd_active    = phase == PH_DATA && cur_rd;
  assign conv_ready   = !(rd_active && cur_sel == SEL_DATA) && !rf.comm[2]
                        && cal_cnt == '0 && !ones_hit;
  assign xfer_len     = (phase == PH_DATA) ? sel_bits(cur_sel) : CNT_W'(8);
  assign load_tx      = cmd_open && cmd_rd;

  always_comb begin
    case (cmd_sel)
      SEL_COMM:   tx_word = {rf.drdy_n, cmd_byte[6:0], {PAD8{1'b0}}};
      SEL_SETUP:  tx_word = {rf.setup, {PAD8{1'b0}}};
      SEL_CLOCK:  tx_word = {rf.clock, {PAD8{1'b0}}};
      SEL_DATA:   tx_word = {rf.data, {PAD16{1'b0}}};
      SEL_TEST:   tx_word = {rf.test, {PAD8{1'b0}}};
      SEL_OFFSET: tx_word = rf.offset;
      SEL_GAIN:   tx_word = rf.gain;
      default:    tx_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf      <= RF_RST;
      phase   <= PH_CMD;
      cur_sel <= SEL_COMM;
      cur_rd  <= 1'b0;
      cal_cnt <= '0;
    end else if (ones_hit) begin
      rf      <= RF_RST;
      phase   <= PH_CMD;
      cur_sel <= SEL_COMM;
      cur_rd  <= 1'b0;
      cal_cnt <= '0;
    end else begin
      if (!cs_act) begin
        phase <= PH_CMD;
      end else if (cmd_take) begin
        rf.comm <= cmd_byte[6:0];
        if (cmd_open) begin
          phase   <= PH_DATA;
          cur_sel <= cmd_sel;
          cur_rd  <= cmd_rd;
        end
      end else if (data_end) begin
        phase <= PH_CMD;
      end

      if (conv_valid && conv_ready) begin
        rf.data   <= conv_data;
        rf.drdy_n <= 1'b0;
      end
      if (rd_data_done) rf.drdy_n <= 1'b1;
      if (cal_cnt != '0) cal_cnt <= cal_cnt - 1'b1;
      if (cal_done) begin
        rf.setup[7:6] <= 2'b00;
        rf.drdy_n     <= 1'b0;
      end

      if (wr_end) begin
        case (cur_sel)
          SEL_SETUP: begin
            rf.setup <= rx_word[7:0];
            cal_cnt  <= (rx_word[7:6] != 2'b00) ? CAL_W'(CAL_CYCLES) : '0;
          end
          SEL_CLOCK:  rf.clock  <= {3'b000, rx_word[4:0]};
          SEL_TEST:   rf.test   <= rx_word[7:0];
          SEL_OFFSET: rf.offset <= rx_word;
          SEL_GAIN:   rf.gain   <= rx_word;
          default: ;
        endcase
      end
    end
  end

  assign drdy_n  = rf.drdy_n;
  assign standby = rf.comm[2];
  assign channel = rf.comm[1:0];
  assign setup_q = rf.setup;
  assign clock_q = rf.clock;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sif_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ONES_RUN    = 32,
  parameter int unsigned CAL_CYCLES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [CONV_W-1:0] conv_data,
  output logic              drdy_n,
  output logic              standby,
  output logic [1:0]        channel
);
  logic              sclk_rise, sclk_fall, cs_act, din_s;
  logic              word_done, ones_hit, sdo_bit, load_tx, rd_active;
  logic              cal_done, rd_data_done, setup_wr;
  logic [CNT_W-1:0]  xfer_len;
  logic [WORD_W-1:0] rx_word, tx_word;
  logic [7:0]        setup_q, clock_q;

  adc_sif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .din_s(din_s)
  );

  adc_sif_shift #(.ONES_RUN(ONES_RUN)) u_shift (
    .clk(clk), .rst_n(rst_n), .rise(sclk_rise), .fall(sclk_fall),
    .cs_act(cs_act), .din(din_s), .xfer_len(xfer_len), .load_tx(load_tx),
    .tx_word(tx_word), .word_done(word_done), .rx_word(rx_word),
    .sdo_bit(sdo_bit), .ones_hit(ones_hit)
  );

  adc_sif_regs #(.CAL_CYCLES(CAL_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .word_done(word_done),
    .rx_word(rx_word), .ones_hit(ones_hit), .conv_valid(conv_valid),
    .conv_data(conv_data), .xfer_len(xfer_len), .load_tx(load_tx),
    .tx_word(tx_word), .rd_active(rd_active), .conv_ready(conv_ready),
    .drdy_n(drdy_n), .standby(standby), .channel(channel),
    .cal_done(cal_done), .rd_data_done(rd_data_done), .setup_wr(setup_wr),
    .setup_q(setup_q), .clock_q(clock_q)
  );

  assign sdo_oe = rd_active && cs_act;
  assign sdo    = sdo_oe & sdo_bit;
endmodule

// File: rtl/adc_sif_checker.sv
module adc_sif_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       word_done,
  input logic       sdo_oe,
  input logic       standby,
  input logic       conv_valid,
  input logic       conv_ready,
  input logic       drdy_n,
  input logic       cal_done,
  input logic       rd_data_done,
  input logic       ones_hit,
  input logic       setup_wr,
  input logic [7:0] setup_q,
  input logic [7:0] clock_q
);
  AST_OE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(word_done)); // R4

  AST_STBY_BLOCKS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !conv_ready); // R8

  AST_DRDY_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> ($past(conv_valid && conv_ready) || $past(cal_done))); // R8

  AST_DRDY_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> ($past(rd_data_done) || $past(ones_hit))); // R9

  AST_CAL_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !setup_wr && !ones_hit) |=> setup_q[7:6] == 2'b00); // R7

  AST_ONES_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> (setup_q == 8'h01 && clock_q == 8'h05 && !standby && drdy_n)); // R10
endmodule

bind adc_serial_port adc_sif_checker u_chk (
  .clk(clk), .rst_n(rst_n), .word_done(word_done), .sdo_oe(sdo_oe),
  .standby(standby), .conv_valid(conv_valid), .conv_ready(conv_ready),
  .drdy_n(drdy_n), .cal_done(cal_done), .rd_data_done(rd_data_done),
  .ones_hit(ones_hit), .setup_wr(setup_wr), .setup_q(setup_q), .clock_q(clock_q)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int HP  = 8;
  localparam int CAL = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic        conv_valid = 1'b0;
  logic [15:0] conv_data = '0;
  logic        sdo, sdo_oe, conv_ready, drdy_n, standby;
  logic [1:0]  channel;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_serial_port #(.CAL_CYCLES(CAL)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sdo(sdo), .sdo_oe(sdo_oe), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_data(conv_data), .drdy_n(drdy_n), .standby(standby), .channel(channel)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi(input logic [31:0] w, input int n, output logic [31:0] r);
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; din = w[i];
      tick(HP);
      r = {r[30:0], sdo};
      sclk = 1'b1;
      tick(HP);
    end
  endtask

  task automatic cs_on();  cs_n = 1'b0; tick(4); endtask
  task automatic cs_off(); tick(4); cs_n = 1'b1; tick(6); endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] v, input int n);
    logic [31:0] r;
    cs_on();
    spi({24'h0, 1'b0, sel, 4'b0000}, 8, r);
    spi(v, n, r);
    cs_off();
  endtask

  task automatic rd_reg(input logic [2:0] sel, input int n, output logic [31:0] r);
    logic [31:0] t;
    cs_on();
    spi({24'h0, 1'b0, sel, 4'b1000}, 8, t);
    spi('1, n, r);
    cs_off();
  endtask

  task automatic cmd(input logic [7:0] b);
    logic [31:0] r;
    cs_on(); spi({24'h0, b}, 8, r); cs_off();
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk("R1 drdy_n", drdy_n, 1); chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 standby", standby, 0); chk("R1 channel", channel, 0);
    chk("R1 conv_ready", conv_ready, 1);
    rd_reg(3'd1, 8, r);  chk("R1 setup", r, 32'h01);
    rd_reg(3'd2, 8, r);  chk("R1 clock", r, 32'h05);
    rd_reg(3'd6, 24, r); chk("R1 offset", r, 32'h800000);
    rd_reg(3'd0, 8, r);  chk("R3 comm readback", r, 32'h88);
  endtask

  task automatic t_command();
    logic [31:0] r;
    cmd(8'h06);
    chk("R2 standby set", standby, 1); chk("R2 channel", channel, 2);
    chk("R8 ready in standby", conv_ready, 0);
    cmd(8'h00);
    cs_on();
    spi(32'h87, 8, r);
    chk("R2 bit7 ignored standby", standby, 0);
    chk("R2 bit7 ignored channel", channel, 0);
    spi(32'h05, 8, r);
    cs_off();
    chk("R2 next byte is command", {standby, channel}, 3'b101);
    cmd(8'h00);
  endtask

  task automatic t_lengths();
    logic [31:0] r;
    wr_reg(3'd6, 32'h123456, 24); rd_reg(3'd6, 24, r); chk("R3 offset 24b", r, 32'h123456);
    wr_reg(3'd7, 32'hABCDEF, 24); rd_reg(3'd7, 24, r); chk("R3 gain 24b", r, 32'hABCDEF);
    wr_reg(3'd4, 32'hA5, 8);      rd_reg(3'd4, 8, r);  chk("R3 test 8b", r, 32'hA5);
    cs_on();
    spi(32'h50, 8, r);
    spi(32'h04, 8, r);
    cs_off();
    chk("R3 nop then command", standby, 1);
    cs_on();
    spi(32'h10, 8, r); spi(32'h24, 8, r);
    spi(32'h00, 8, r);
    cs_off();
    chk("R3 command after data", standby, 0);
    rd_reg(3'd1, 8, r); chk("R3 setup in same frame", r, 32'h24);
  endtask

  task automatic t_clock();
    logic [31:0] r;
    wr_reg(3'd2, 32'hFF, 8); rd_reg(3'd2, 8, r); chk("R5 reserved bits", r, 32'h1F);
    wr_reg(3'd2, 32'h05, 8);
  endtask

  task automatic t_conv_read();
    logic [31:0] r;
    @(negedge clk); conv_data = 16'hBEEF; conv_valid = 1'b1;
    @(negedge clk); conv_valid = 1'b0;
    chk("R8 drdy low", drdy_n, 0);
    cs_on();
    chk("R4 oe idle in command", sdo_oe, 0);
    spi(32'h38, 8, r);
    tick(2);
    chk("R4 oe in read", sdo_oe, 1);
    spi('1, 16, r);
    chk("R4 msb first data", r, 32'hBEEF);
    cs_off();
    chk("R4 oe after release", sdo_oe, 0);
    chk("R9 drdy high after read", drdy_n, 1);
  endtask

  task automatic t_collision();
    logic [31:0] r;
    @(negedge clk); conv_data = 16'h1111; conv_valid = 1'b1;
    @(negedge clk); conv_valid = 1'b0;
    cs_on();
    spi(32'h38, 8, r);
    tick(2);
    conv_data = 16'h2222; conv_valid = 1'b1;
    tick(1);
    chk("R8 ready low during read", conv_ready, 0);
    spi('1, 16, r);
    chk("R8 old word intact", r, 32'h1111);
    cs_off();
    conv_valid = 1'b0;
    chk("R9 drdy low again after held word", drdy_n, 0);
    rd_reg(3'd3, 16, r); chk("R8 held word accepted", r, 32'h2222);
  endtask

  task automatic t_data_write();
    logic [31:0] r;
    wr_reg(3'd3, 32'h1234, 16);
    rd_reg(3'd3, 16, r); chk("R6 data write dropped", r, 32'h2222);
  endtask

  task automatic t_cal();
    logic [31:0] r;
    wr_reg(3'd1, 32'h40, 8);
    chk("R7 ready low while calibrating", conv_ready, 0);
    rd_reg(3'd1, 8, r); chk("R7 mode held", r, 32'h40);
    chk("R7 drdy high while busy", drdy_n, 1);
    tick(CAL);
    chk("R7 drdy low at end", drdy_n, 0);
    rd_reg(3'd1, 8, r); chk("R7 mode cleared", r, 32'h00);
  endtask

  task automatic t_resync();
    logic [31:0] r;
    cs_on(); spi(32'h0, 3, r); cs_off();
    cmd(8'h04);
    chk("R11 partial byte discarded", standby, 1);
    cmd(8'h00);
  endtask

  task automatic t_ones();
    logic [31:0] r;
    wr_reg(3'd1, 32'h3C, 8);
    cs_on(); spi('1, 31, r); cs_off();
    rd_reg(3'd1, 8, r); chk("R10 31 ones no reset", r, 32'h3C);
    wr_reg(3'd2, 32'h1A, 8);
    cmd(8'h06);
    cs_on(); spi('1, 32, r); cs_off();
    chk("R10 standby cleared", standby, 0);
    chk("R10 channel cleared", channel, 0);
    rd_reg(3'd1, 8, r);  chk("R10 setup default", r, 32'h01);
    rd_reg(3'd2, 8, r);  chk("R10 clock default", r, 32'h05);
    rd_reg(3'd6, 24, r); chk("R10 offset default", r, 32'h800000);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_command();
    t_lengths();
    t_clock();
    t_conv_read();
    t_collision();
    t_data_write();
    t_cal();
    t_resync();
    t_ones();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule